// File: doc/BRIEF.md
# Split Biquinary Decade Counter

This block is a decimal counting cell made of two sections that advance on their own: a one-bit section that divides by two and a three-bit section that divides by five. Each section has its own count input and advances when that input falls from high to low. When the one-bit output is wired back into the count input of the five-state section, the four outputs step through the decimal digits 0 to 9 in plain BCD and then return to 0. If the two sections are used apart, they give separate divide-by-2 and divide-by-5 counts.

The count inputs are not used as clocks. Each one passes through a synchronizer chain of `SYNC_STAGES` flops clocked by `clk`. A falling edge detector then turns it into a one-cycle advance strobe. Two pairs of gated control inputs override the count. When both inputs of the zero pair are high, the outputs read 0000. When both inputs of the nine pair are high, the outputs read 1001. The override reaches the outputs through logic only, with no clock needed, and it is loaded into the state registers on every clock for as long as it is held. A control must therefore stay high for at least `SYNC_STAGES`+2 clocks before the forced value is kept after release.

Top module: `biquinary_decade`

## Requirements
- R1: Each falling edge on `cnt_a` toggles `q_d0`. The new value shows within `SYNC_STAGES`+1 clocks, and `{q_d3,q_d2,q_d1}` does not change.
- R2: Each falling edge on `cnt_b` advances the five-state section `{q_d3,q_d2,q_d1}` through 000, 001, 010, 011, 100 and back to 000.
- R3: A rising edge on either count input changes no output.
- R4: When `cnt_b` is driven from `q_d0`, the outputs `{q_d3,q_d2,q_d1,q_d0}` follow a modulo-10 count in BCD. The count goes from 1001 straight to 0000 and never shows a value above 1001.
- R5: When `zero_req_a` and `zero_req_b` are both high, the outputs read 0000 in the same cycle. After a hold of at least `SYNC_STAGES`+2 clocks, they stay at 0000 once the controls are released.
- R6: Raising only one input of the zero pair, or only one input of the nine pair, leaves the count unchanged.
- R7: When `nine_req_a` and `nine_req_b` are both high, the outputs read 1001 in the same cycle, and they keep 1001 after release. The next A-count in chained mode then gives 0000.
- R8: When both pairs are active together, the nine pair wins and the outputs read 1001.
- R9: Falling edges on the count inputs while an override is active have no effect.
- R10: While `rst_n` is low, the outputs read 0000 unless the nine pair is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the count inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_a | input | 1 | Count input of the two-state section, falling edge counts |
| cnt_b | input | 1 | Count input of the five-state section, falling edge counts |
| zero_req_a | input | 1 | Zero-force request, first gate input |
| zero_req_b | input | 1 | Zero-force request, second gate input |
| nine_req_a | input | 1 | Nine-force request, first gate input |
| nine_req_b | input | 1 | Nine-force request, second gate input |
| q_d0 | output | 1 | Output of the two-state section, BCD weight 1 |
| q_d1 | output | 1 | Five-state section bit, BCD weight 2 |
| q_d2 | output | 1 | Five-state section bit, BCD weight 4 |
| q_d3 | output | 1 | Five-state section bit, BCD weight 8 |

## Verification
The bench runs every state of each section apart and then more than 25 chained counts against an arithmetic modulo-10 model. A five-state section that wraps at the wrong value would show 1010 or 1011, and one that counted on rising edges would run half a period early. The override tests apply a single gate input, both pairs together, and count pulses during a hold. A design with OR gating, the wrong priority, or counting that leaks through an override would leave the wrong digit after release. The release after forcing nine checks that the next count wraps cleanly to zero through the chained carry.

// File: rtl/biquinary_pkg.sv
package biquinary_pkg;
  localparam int QUI_W = 3;
  localparam int QUI_STATES = 5;

  typedef logic [QUI_W-1:0] qui_t;

  localparam qui_t QUI_LAST = qui_t'(QUI_STATES - 1);
  // Upper three bits of decimal nine (1001 -> 100)
  localparam qui_t QUI_NINE = 3'b100;

  typedef struct packed {
    logic hold;     // an override is active
    logic to_nine;  // override value: nine (1) or zero (0)
  } force_t;

  function automatic qui_t qui_next(qui_t cur);
    return (cur == QUI_LAST) ? '0 : qui_t'(cur + 1'b1);
  endfunction
endpackage

// File: rtl/bq_fall_detect.sv
module bq_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= din;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];

  assign fall = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/bq_force_gate.sv
module bq_force_gate
  import biquinary_pkg::*;
(
  input  logic   zero_a,
  input  logic   zero_b,
  input  logic   nine_a,
  input  logic   nine_b,
  output force_t frc
);
  logic zero_both, nine_both;
  assign zero_both   = zero_a & zero_b;
  assign nine_both   = nine_a & nine_b;
  assign frc.hold    = zero_both | nine_both;
  assign frc.to_nine = nine_both;   // nine has priority over zero
endmodule

// File: rtl/bq_binary_stage.sv
module bq_binary_stage
  import biquinary_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv,
  input  force_t frc,
  output logic   q
);
  logic q_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        q_r <= 1'b0;
    else if (frc.hold) q_r <= frc.to_nine;
    else if (adv)      q_r <= ~q_r;

  assign q = frc.hold ? frc.to_nine : q_r;
endmodule

// File: rtl/bq_quinary_stage.sv
module bq_quinary_stage
  import biquinary_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   adv,
  input  force_t frc,
  output qui_t   q
);
  qui_t q_r, forced;

  assign forced = frc.to_nine ? QUI_NINE : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        q_r <= '0;
    else if (frc.hold) q_r <= forced;
    else if (adv)      q_r <= qui_next(q_r);

  assign q = frc.hold ? forced : q_r;
endmodule

// File: rtl/biquinary_decade.sv
module biquinary_decade
  import biquinary_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_a,
  input  logic cnt_b,
  input  logic zero_req_a,
  input  logic zero_req_b,
  input  logic nine_req_a,
  input  logic nine_req_b,
  output logic q_d0,
  output logic q_d1,
  output logic q_d2,
  output logic q_d3
);
  localparam int SYNC_N = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  force_t frc;
  logic   adv_a, adv_b;
  qui_t   hi;

  bq_force_gate u_gate (
    .zero_a(zero_req_a), .zero_b(zero_req_b),
    .nine_a(nine_req_a), .nine_b(nine_req_b),
    .frc(frc)
  );

  bq_fall_detect #(.STAGES(SYNC_N)) u_edge_a (
    .clk(clk), .rst_n(rst_n), .din(cnt_a), .fall(adv_a)
  );

  bq_fall_detect #(.STAGES(SYNC_N)) u_edge_b (
    .clk(clk), .rst_n(rst_n), .din(cnt_b), .fall(adv_b)
  );

  bq_binary_stage u_two (
    .clk(clk), .rst_n(rst_n), .adv(adv_a), .frc(frc), .q(q_d0)
  );

  bq_quinary_stage u_five (
    .clk(clk), .rst_n(rst_n), .adv(adv_b), .frc(frc), .q(hi)
  );

  assign q_d1 = hi[0];
  assign q_d2 = hi[1];
  assign q_d3 = hi[2];
endmodule

// File: rtl/biquinary_decade_chk.sv
module biquinary_decade_chk (
  input logic clk,
  input logic rst_n,
  input logic cnt_a,
  input logic cnt_b,
  input logic zero_req_a,
  input logic zero_req_b,
  input logic nine_req_a,
  input logic nine_req_b,
  input logic q_d0,
  input logic q_d1,
  input logic q_d2,
  input logic q_d3
);
  logic       zero_on, nine_on, any_on, rst_seen;
  logic [2:0] hi;
  logic [3:0] val;

  assign zero_on = zero_req_a & zero_req_b;
  assign nine_on = nine_req_a & nine_req_b;
  assign any_on  = zero_on | nine_on;
  assign hi      = {q_d3, q_d2, q_d1};
  assign val     = {q_d3, q_d2, q_d1, q_d0};

  function automatic logic [2:0] step5(logic [2:0] v);
    return (v == 3'd4) ? 3'd0 : v + 3'd1;
  endfunction

  always_ff @(posedge clk) rst_seen <= !rst_n;

  assert_bcd_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    val <= 4'd9);

  assert_mod5_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_on && !$past(any_on) && hi != $past(hi)) |-> hi == step5($past(hi)));

  assert_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_on && !nine_on) |-> val == 4'd0);

  assert_nine_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_on && !zero_on) |-> val == 4'd9);

  assert_nine_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_on && zero_on) |-> val == 4'd9);

  assert_retain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(any_on) && !any_on) |-> val == $past(val));

  always @(posedge clk)
    if (rst_seen && !rst_n && !nine_on)
      assert_reset_R10: assert (val == 4'd0);
endmodule

bind biquinary_decade biquinary_decade_chk u_chk (.*);

// File: tb/biquinary_decade_bench.sv
module biquinary_decade_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_a = 1'b0, b_drv = 1'b0, chain = 1'b0;
  logic zero_req_a = 1'b0, zero_req_b = 1'b0;
  logic nine_req_a = 1'b0, nine_req_b = 1'b0;
  logic q_d0, q_d1, q_d2, q_d3;
  logic cnt_b;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  assign cnt_b = chain ? q_d0 : b_drv;

  always #4 clk = ~clk;   // 125 MHz

  biquinary_decade u_biquinary_decade (
    .clk(clk), .rst_n(rst_n), .cnt_a(cnt_a), .cnt_b(cnt_b),
    .zero_req_a(zero_req_a), .zero_req_b(zero_req_b),
    .nine_req_a(nine_req_a), .nine_req_b(nine_req_b),
    .q_d0(q_d0), .q_d1(q_d1), .q_d2(q_d2), .q_d3(q_d3)
  );

  function automatic logic [3:0] val();
    return {q_d3, q_d2, q_d1, q_d0};
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_a();
    cnt_a = 1'b1; clks(4);
    cnt_a = 1'b0; clks(8);
  endtask

  task automatic pulse_b();
    b_drv = 1'b1; clks(4);
    b_drv = 1'b0; clks(8);
  endtask

  task automatic force_zero(input int hold);
    zero_req_a = 1'b1; zero_req_b = 1'b1; #1;
    chk("R5 immediate", val(), 4'd0);
    clks(hold);
    zero_req_a = 1'b0; zero_req_b = 1'b0; clks(4);
  endtask

  initial begin
    int ref_v;
    clks(3);
    chk("R10 in reset", val(), 4'd0);
    rst_n = 1'b1; clks(3);
    chk("R10 after reset", val(), 4'd0);

    // R1: A alone, section toggles, upper bits stay
    for (int i = 1; i <= 6; i++) begin
      pulse_a();
      chk("R1 toggle", val(), 4'(i % 2));
    end
    // R2: B alone through every state
    for (int i = 1; i <= 11; i++) begin
      pulse_b();
      chk("R2 mod5", {1'b0, q_d3, q_d2, q_d1}, 4'(i % 5));
    end
    // R3: rising edge only
    force_zero(6);
    cnt_a = 1'b1; clks(8);
    chk("R3 rise A", val(), 4'd0);
    b_drv = 1'b1; clks(8);
    chk("R3 rise B", val(), 4'd0);
    cnt_a = 1'b0; b_drv = 1'b0; clks(8);
    chk("R3 fall after rise", val(), 4'd3);   // A fall -> d0=1, B fall -> hi=1
    force_zero(6);

    // R4: chained BCD count
    chain = 1'b1; clks(2);
    ref_v = 0;
    for (int i = 0; i < 27; i++) begin
      pulse_a();
      ref_v = (ref_v + 1) % 10;
      chk("R4 chained", val(), 4'(ref_v));
    end

    // R5: zero pair clears and retains
    chk("R5 before", val(), 4'(ref_v));
    force_zero(6);
    chk("R5 retained", val(), 4'd0);

    // R6: single gate inputs do nothing
    for (int i = 0; i < 3; i++) pulse_a();
    zero_req_a = 1'b1; clks(6);
    chk("R6 zero_a only", val(), 4'd3);
    zero_req_a = 1'b0; zero_req_b = 1'b1; clks(6);
    chk("R6 zero_b only", val(), 4'd3);
    zero_req_b = 1'b0; nine_req_a = 1'b1; clks(6);
    chk("R6 nine_a only", val(), 4'd3);
    nine_req_a = 1'b0; nine_req_b = 1'b1; clks(6);
    chk("R6 nine_b only", val(), 4'd3);
    nine_req_b = 1'b0; clks(2);

    // R7: nine pair
    nine_req_a = 1'b1; nine_req_b = 1'b1; #1;
    chk("R7 immediate", val(), 4'd9);
    clks(6);
    nine_req_a = 1'b0; nine_req_b = 1'b0; clks(4);
    chk("R7 retained", val(), 4'd9);
    pulse_a();
    chk("R7 wrap to 0", val(), 4'd0);

    // R8: both pairs
    pulse_a(); pulse_a();
    zero_req_a = 1'b1; zero_req_b = 1'b1;
    nine_req_a = 1'b1; nine_req_b = 1'b1; #1;
    chk("R8 priority", val(), 4'd9);
    clks(6);
    {zero_req_a, zero_req_b, nine_req_a, nine_req_b} = 4'b0; clks(4);
    chk("R8 retained", val(), 4'd9);

    // R9: counting blocked during override
    zero_req_a = 1'b1; zero_req_b = 1'b1; clks(2);
    pulse_a(); pulse_a(); pulse_a();
    chk("R9 during hold", val(), 4'd0);
    zero_req_a = 1'b0; zero_req_b = 1'b0; clks(10);
    chk("R9 after release", val(), 4'd0);
    pulse_a();
    chk("R9 counts again", val(), 4'd1);

    // R10: reset in the middle of a count
    pulse_a(); pulse_a();
    rst_n = 1'b0; clks(2);
    chk("R10 mid-count reset", val(), 4'd0);
    rst_n = 1'b1; clks(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule